// File: doc/BRIEF.md
# Two-Byte Receive Byte Ordering Aligner

This block sits on a receive path that carries two bytes per clock, one in a low lane and one in a high lane. The high lane carries the earlier byte of each word. The block waits for an upstream word aligner to report lock, then searches for a programmable marker byte. The goal is to deliver that marker in the low lane of the output.

If the first marker after lock arrives in the high lane, the block inserts one programmable pad byte ahead of it. From that point the stream is shifted by one lane for good. If the marker arrives in the low lane, the stream passes through unchanged. In both cases a status flag rises with the output word that carries the marker.

Every output is registered once. The flag is cleared by a drop of the lock signal or by a fresh rising edge, and a rising edge also restarts the search.

Top module: `byte_order_align`

## Requirements
- R1: With no shift in force and no decision in the current cycle, `data_o` equals the `data_i` of the previous cycle (one register stage).
- R2: A marker is acted on only in a cycle where `sync_i` is high and a rising edge of `sync_i` has occurred with no decision since. Such a cycle includes the cycle in which `sync_i` rises. A marker seen while `sync_i` is low, or before any rising edge, changes neither the data nor the status.
- R3: If the first marker after a rising edge is in the low lane (`data_i[7:0]`), the next `data_o` equals that input word unchanged and `aligned_o` is 1 in the same cycle.
- R4: If the first marker after a rising edge is in the high lane (`data_i[15:8]`), the next `data_o` is `{pad_i, marker}`, with the pad in `data_o[15:8]`, and `aligned_o` is 1 in the same cycle.
- R5: After a high-lane insertion, each `data_o` is `{low byte of the previous input word, high byte of the current input word}`.
- R6: Once a decision is made, later markers pass through as ordinary data until the next rising edge of `sync_i`.
- R7: When both lanes of the first matching word hold the marker, the low lane wins and no pad is inserted.
- R8: `aligned_o` stays at 1 while `sync_i` stays high. One cycle after `sync_i` is low, `aligned_o` is 0.
- R9: A new rising edge of `sync_i` clears `aligned_o` (unless that same word decides) and starts a new search. The existing lane shift stays in force until the new decision.
- R10: Reset (`rst_ni` low, asynchronous) forces `data_o` to 0 and `aligned_o` to 0, and leaves the block unshifted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_i | input | 1 | Lock status from the word aligner |
| data_i | input | 16 | Input word; `[15:8]` is the earlier byte |
| marker_i | input | 8 | Byte value to place in the low lane |
| pad_i | input | 8 | Byte inserted on a high-lane match |
| data_o | output | 16 | Ordered output word |
| aligned_o | output | 1 | Ordering done since the last rising edge |

## Verification
Every result, whether data, pad insertion or status, is due exactly one clock edge after the input word that causes it. The exception is the reset effect, which is immediate. The bench drives each word on the falling edge and compares `data_o` and `aligned_o` 1 ns after the next rising edge. That comparison sees the registered effect of that word and nothing later. The expected words for the shifted case are worked out by hand from the previous input's low byte, so any extra or missing register stage shows up as a miscompare.

// File: rtl/bo_pkg.sv
package bo_pkg;
  localparam int unsigned LANES = 2;

  typedef enum logic {
    MODE_DIRECT  = 1'b0,
    MODE_SHIFTED = 1'b1
  } lane_mode_e;
endpackage

// File: rtl/bo_match.sv
module bo_match #(
  parameter int unsigned LANE_W = 8,
  parameter int unsigned LANES  = 2
) (
  input  logic [LANES*LANE_W-1:0] data_i,
  input  logic [LANE_W-1:0]       marker_i,
  output logic [LANES-1:0]        hit_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign hit_o[g] = (data_i[g*LANE_W +: LANE_W] == marker_i);
  end
endmodule

// File: rtl/bo_ctrl.sv
module bo_ctrl
  import bo_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sync_i,
  input  logic       hit_lo_i,
  input  logic       hit_hi_i,
  output logic       take_lo_o,
  output logic       take_hi_o,
  output logic       sync_rise_o,
  output lane_mode_e mode_o,
  output logic       aligned_o
);
  logic       sync_q, armed_q, aligned_q;
  lane_mode_e mode_q;
  logic       search;

  assign sync_rise_o = sync_i & ~sync_q;
  // search window: rising-edge cycle onward, until the first decision
  assign search      = sync_i & (sync_rise_o | armed_q);
  assign take_lo_o   = search & hit_lo_i;
  assign take_hi_o   = search & hit_hi_i & ~hit_lo_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q    <= 1'b0;
      armed_q   <= 1'b0;
      aligned_q <= 1'b0;
      mode_q    <= MODE_DIRECT;
    end else begin
      sync_q    <= sync_i;
      armed_q   <= search & ~(hit_lo_i | hit_hi_i);
      aligned_q <= take_lo_o | take_hi_o | (aligned_q & sync_i & ~sync_rise_o);
      if (take_lo_o)      mode_q <= MODE_DIRECT;
      else if (take_hi_o) mode_q <= MODE_SHIFTED;
    end
  end

  assign mode_o    = mode_q;
  assign aligned_o = aligned_q;
endmodule

// File: rtl/bo_shifter.sv
module bo_shifter
  import bo_pkg::*;
#(
  parameter int unsigned LANE_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [2*LANE_W-1:0] data_i,
  input  logic [LANE_W-1:0]   pad_i,
  input  logic                take_lo_i,
  input  logic                take_hi_i,
  input  lane_mode_e          mode_i,
  output logic [2*LANE_W-1:0] data_o
);
  localparam int unsigned WORD_W = 2 * LANE_W;

  logic [LANE_W-1:0] hold_q;
  logic [WORD_W-1:0] word_d, word_q;
  logic [LANE_W-1:0] lo_b, hi_b;

  assign lo_b = data_i[LANE_W-1:0];
  assign hi_b = data_i[WORD_W-1:LANE_W];

  always_comb begin
    if (take_lo_i)                   word_d = data_i;
    else if (take_hi_i)              word_d = {pad_i, hi_b};
    else if (mode_i == MODE_SHIFTED) word_d = {hold_q, hi_b};
    else                             word_d = data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      word_q <= '0;
    end else begin
      hold_q <= lo_b;
      word_q <= word_d;
    end
  end

  assign data_o = word_q;
endmodule

// File: rtl/byte_order_align.sv
module byte_order_align
  import bo_pkg::*;
#(
  parameter int unsigned LANE_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sync_i,
  input  logic [2*LANE_W-1:0] data_i,
  input  logic [LANE_W-1:0]   marker_i,
  input  logic [LANE_W-1:0]   pad_i,
  output logic [2*LANE_W-1:0] data_o,
  output logic                aligned_o
);
  logic [LANES-1:0] hit;
  logic             take_lo, take_hi, sync_rise;
  lane_mode_e       mode;

  bo_match #(.LANE_W(LANE_W), .LANES(LANES)) u_match (
    .data_i   (data_i),
    .marker_i (marker_i),
    .hit_o    (hit)
  );

  bo_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sync_i      (sync_i),
    .hit_lo_i    (hit[0]),
    .hit_hi_i    (hit[1]),
    .take_lo_o   (take_lo),
    .take_hi_o   (take_hi),
    .sync_rise_o (sync_rise),
    .mode_o      (mode),
    .aligned_o   (aligned_o)
  );

  bo_shifter #(.LANE_W(LANE_W)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .data_i    (data_i),
    .pad_i     (pad_i),
    .take_lo_i (take_lo),
    .take_hi_i (take_hi),
    .mode_i    (mode),
    .data_o    (data_o)
  );
endmodule

// File: rtl/byte_order_align_chk.sv
module byte_order_align_chk
  import bo_pkg::*;
#(
  parameter int unsigned LANE_W = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                sync_i,
  input logic [2*LANE_W-1:0] data_i,
  input logic [LANE_W-1:0]   pad_i,
  input logic [2*LANE_W-1:0] data_o,
  input logic                aligned_o,
  input logic                take_lo,
  input logic                take_hi,
  input logic                sync_rise,
  input lane_mode_e          mode
);
  assert_pass_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!take_lo && !take_hi && mode == MODE_DIRECT) |=> data_o == $past(data_i));

  assert_decide_sync_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_lo || take_hi) |-> sync_i);

  assert_low_hit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_lo |=> (data_o == $past(data_i)) && aligned_o);

  assert_pad_insert_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_hi |=> (data_o == {$past(pad_i), $past(data_i[2*LANE_W-1:LANE_W])}) && aligned_o);

  assert_shifted_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!take_lo && !take_hi && mode == MODE_SHIFTED)
      |=> data_o == {$past(data_i[LANE_W-1:0], 2), $past(data_i[2*LANE_W-1:LANE_W])});

  assert_drop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync_i |=> !aligned_o);

  assert_rearm_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_rise |=> (!aligned_o || $past(take_lo || take_hi)));

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aligned_o && sync_i && !sync_rise) |=> aligned_o);
endmodule

bind byte_order_align byte_order_align_chk #(.LANE_W(LANE_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sync_i    (sync_i),
  .data_i    (data_i),
  .pad_i     (pad_i),
  .data_o    (data_o),
  .aligned_o (aligned_o),
  .take_lo   (take_lo),
  .take_hi   (take_hi),
  .sync_rise (sync_rise),
  .mode      (mode)
);

// File: tb/sim_byte_order_align.sv
`timescale 1ns/1ps
module sim_byte_order_align;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sync = 1'b0;
  logic [15:0] din = '0;
  logic [7:0]  marker = 8'hBC;
  logic [7:0]  pad = 8'h9C;
  logic [15:0] dout;
  logic        al;
  int          n_chk = 0;
  int          n_err = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  byte_order_align u0 (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .sync_i    (sync),
    .data_i    (din),
    .marker_i  (marker),
    .pad_i     (pad),
    .data_o    (dout),
    .aligned_o (al)
  );

  localparam int NV = 17;
  // {sync, data_i, expected data_o, expected aligned_o}; marker BC, pad 9C
  localparam logic [33:0] VEC [NV] = '{
    {1'b0, 16'h11BC, 16'h11BC, 1'b0}, // R2 marker ignored, sync low
    {1'b1, 16'h2233, 16'h2233, 1'b0}, // R1 rise, no match
    {1'b1, 16'hBC44, 16'h9CBC, 1'b1}, // R4 high-lane match
    {1'b1, 16'h5566, 16'h4455, 1'b1}, // R5
    {1'b1, 16'hBC77, 16'h66BC, 1'b1}, // R6 later marker passes
    {1'b1, 16'h8899, 16'h7788, 1'b1}, // R5
    {1'b0, 16'hAABB, 16'h99AA, 1'b0}, // R8 drop
    {1'b0, 16'h12BC, 16'hBB12, 1'b0}, // R8 ignored while low
    {1'b1, 16'h3456, 16'hBC34, 1'b0}, // R9 shift kept, status cleared
    {1'b1, 16'h78BC, 16'h78BC, 1'b1}, // R3 low-lane match
    {1'b1, 16'h9ABC, 16'h9ABC, 1'b1}, // R6
    {1'b0, 16'h0102, 16'h0102, 1'b0}, // R8
    {1'b1, 16'hBCBC, 16'hBCBC, 1'b1}, // R7 both lanes
    {1'b1, 16'h0304, 16'h0304, 1'b1}, // R8 hold
    {1'b0, 16'h0506, 16'h0506, 1'b0}, // R8
    {1'b1, 16'hBC07, 16'h9CBC, 1'b1}, // R4 rise and match same word
    {1'b1, 16'h0809, 16'h0708, 1'b1}  // R5
  };
  localparam int VREQ [NV] = '{2, 1, 4, 5, 6, 5, 8, 8, 9, 3, 6, 8, 7, 8, 8, 4, 5};

  task automatic check(input string req, input logic [15:0] ed, input logic ea);
    n_chk++;
    if (dout !== ed || al !== ea) begin
      n_err++;
      $display("FAIL %s data=%h aligned=%b expected data=%h aligned=%b", req, dout, al, ed, ea);
    end
  endtask

  task automatic apply(input logic s, input logic [15:0] d);
    @(negedge clk);
    sync = s;
    din  = d;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #3;
    check("R10", 16'h0000, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][33], VEC[i][32:17]);
      check($sformatf("R%0d", VREQ[i]), VEC[i][16:1], VEC[i][0]);
    end
    // R10: asynchronous reset in a shifted, aligned state
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R10", 16'h0000, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    apply(1'b0, 16'h1234);
    check("R10", 16'h1234, 1'b0);
    // R2: marker with sync held high but no rising edge since decision
    apply(1'b1, 16'hBC00);
    check("R4", 16'h9CBC, 1'b1);
    apply(1'b1, 16'h00BC);
    check("R6", 16'h0000, 1'b1);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog R1 actual=hung expected=complete");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end
endmodule